// File: doc/BRIEF.md
# Tick Compare Timer Unit

The unit keeps a free-running system tick counter and two compare channels. One channel serves the supervisor and the other the hypervisor. Each compare register holds a compare value in its low `CNT_W` bits and an interrupt-disable flag in its top bit (bit `CNT_W`, bit 63 at the default width). A channel fires when an advancing counter lands on its compare value. The supervisor channel emits a one-cycle pulse that sets the tick bit (bit 16) of an external soft interrupt register. The hypervisor channel sets a one-bit pending register, and that register drives an interrupt line until software clears it.

Software reaches the unit through a small register port. Writes are synchronous, one register per cycle. Reads are combinational on a separate address. The register addresses are 0 for the counter (read-only), 1 for the supervisor compare, 2 for the hypervisor compare and 3 for the hypervisor pending flag, which sits in bit 0.

Each channel is a three-state machine:
- CH_OFF: disabled.
- CH_ARMED: enabled and waiting.
- CH_HIT: the single cycle in which the count reaches the value.

Its transitions are:
- A compare write moves the channel to CH_OFF when the written top bit is 1, or to CH_ARMED when it is 0, from any state.
- An arrival moves CH_ARMED or CH_HIT to CH_HIT.
- Without an arrival, CH_HIT returns to CH_ARMED.

The pending register is a two-state machine:
- PEND_CLEAR goes to PEND_RAISED on a hypervisor hit, or on a software write of 1.
- PEND_RAISED goes to PEND_CLEAR only on a software write of 0 in a cycle without a hit.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset:
  - the counter reads 0;
  - both compare registers read with the disable bit (bit `CNT_W`) set and a zero value;
  - the pending flag reads 0;
  - `soft_tick_set` and `hv_irq` are low.
- R2: The counter increases by one on each clock edge where `tick_en` is high, holds otherwise, and wraps modulo 2^`CNT_W`. It reads at address 0, zero-extended.
- R3: A write to address 1 (supervisor) or 2 (hypervisor) stores all `CNT_W`+1 bits of `wr_data`, and the register reads back unchanged at the same address.
- R4: With its disable bit clear, the supervisor channel raises `soft_tick_set` for exactly one cycle. That cycle is the first one in which the counter, having just advanced, equals the low `CNT_W` bits of the compare register.
- R5: A compare register whose bit `CNT_W` is 1 produces no pulse, whatever the count.
- R6: A compare value equal to the count at the time of the write fires only after the counter has advanced a full 2^`CNT_W` ticks. A value d ticks ahead fires after d ticks.
- R7: A hypervisor hit sets the pending flag on the next edge. `hv_irq` follows the flag and stays high until software writes 0 to bit 0 of address 3.
- R8: While `hv_thread_live` is low, the hypervisor channel does not fire.
- R9: Writing a compare register with bit `CNT_W` set cancels a match that was armed on that channel.
- R10: When a hypervisor hit and a software write to the pending flag fall in the same cycle, the flag ends up set.
- R11: Address 3 reads the pending flag in bit 0 with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the counter this cycle |
| hv_thread_live | input | 1 | Hypervisor thread is running (not halted or unallocated) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W+1 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W+1 | Read data |
| soft_tick_set | output | 1 | One-cycle pulse that sets soft interrupt bit 16 |
| hv_irq | output | 1 | Hypervisor interrupt, high while pending flag is set |

## Verification
The assertions check several properties on every cycle:
- the counter's one-step advance and its hold;
- that a supervisor pulse lasts one cycle and only coincides with the counter equal to an enabled compare value;
- that a disabled compare stays silent;
- that no hypervisor hit follows a cycle with the thread down;
- that the pending flag rises after a hit and stays up until a clearing write.

Only the bench's scenarios can show the rest:
- the exact firing delay for every compare value against the running count, including the full-wrap case of R6;
- that cancelling a write really removes an armed match;
- the outcome of a same-cycle hit and clearing write.

// File: rtl/tct_pkg.sv
package tct_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_HIT   = 2'd2
    } ch_state_t;

    typedef enum logic {
        PEND_CLEAR  = 1'b0,
        PEND_RAISED = 1'b1
    } pend_state_t;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_COUNT   = 2'd0;
    localparam logic [ADDR_W-1:0] A_SV_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_HV_CMP  = 2'd2;
    localparam logic [ADDR_W-1:0] A_HV_PEND = 2'd3;
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] step_val
);
    // value the counter takes on an advancing edge (wraps naturally)
    assign step_val = count_q + {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (tick_en) count_q <= step_val;
    end
endmodule

// File: rtl/tct_channel.sv
module tct_channel
    import tct_pkg::*;
#(
    parameter int CNT_W = 63,
    parameter bit GATED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [CNT_W:0]   wr_data,
    input  logic             tick_en,
    input  logic             live,
    input  logic [CNT_W-1:0] step_val,
    output logic [CNT_W:0]   cmp_q,
    output logic             hit
);
    localparam int DIS_BIT = CNT_W;

    ch_state_t state_q, state_d;
    logic      arrive_raw, arrive;

    assign arrive_raw = tick_en && (step_val == cmp_q[CNT_W-1:0]);

    generate
        if (GATED) begin : g_gate
            assign arrive = arrive_raw && live;
        end else begin : g_free
            assign arrive = arrive_raw;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= {1'b1, {CNT_W{1'b0}}};
        else if (wr_sel) cmp_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (wr_sel) state_d = wr_data[DIS_BIT] ? CH_OFF : CH_ARMED;
            end
            CH_ARMED: begin
                if (wr_sel)      state_d = wr_data[DIS_BIT] ? CH_OFF : CH_ARMED;
                else if (arrive) state_d = CH_HIT;
            end
            CH_HIT: begin
                if (wr_sel)      state_d = wr_data[DIS_BIT] ? CH_OFF : CH_ARMED;
                else if (arrive) state_d = CH_HIT;
                else             state_d = CH_ARMED;
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        hit = (state_q == CH_HIT);
    end
endmodule

// File: rtl/tct_pending.sv
module tct_pending
    import tct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic wr_sel,
    input  logic wr_bit,
    output logic pend
);
    pend_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEND_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_CLEAR: begin
                if (set_req || (wr_sel && wr_bit)) state_d = PEND_RAISED;
            end
            PEND_RAISED: begin
                if (!set_req && wr_sel && !wr_bit) state_d = PEND_CLEAR;
            end
            default: state_d = PEND_CLEAR;
        endcase
    end

    always_comb begin
        pend = (state_q == PEND_RAISED);
    end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tct_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              hv_thread_live,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W:0]    wr_data,
    input  logic [1:0]        rd_addr,
    output logic [CNT_W:0]    rd_data,
    output logic              soft_tick_set,
    output logic              hv_irq
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] step_val;
    logic [CNT_W:0]   sv_cmp;
    logic [CNT_W:0]   hv_cmp;
    logic             sv_hit;
    logic             hv_hit;
    logic             hv_pend;

    tct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .count_q  (count_q),
        .step_val (step_val)
    );

    tct_channel #(.CNT_W(CNT_W), .GATED(1'b0)) u_sv_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_en && (wr_addr == A_SV_CMP)),
        .wr_data  (wr_data),
        .tick_en  (tick_en),
        .live     (1'b1),
        .step_val (step_val),
        .cmp_q    (sv_cmp),
        .hit      (sv_hit)
    );

    tct_channel #(.CNT_W(CNT_W), .GATED(1'b1)) u_hv_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_en && (wr_addr == A_HV_CMP)),
        .wr_data  (wr_data),
        .tick_en  (tick_en),
        .live     (hv_thread_live),
        .step_val (step_val),
        .cmp_q    (hv_cmp),
        .hit      (hv_hit)
    );

    tct_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (hv_hit),
        .wr_sel  (wr_en && (wr_addr == A_HV_PEND)),
        .wr_bit  (wr_data[0]),
        .pend    (hv_pend)
    );

    assign soft_tick_set = sv_hit;
    assign hv_irq        = hv_pend;

    always_comb begin
        unique case (rd_addr)
            A_COUNT:   rd_data = {1'b0, count_q};
            A_SV_CMP:  rd_data = sv_cmp;
            A_HV_CMP:  rd_data = hv_cmp;
            A_HV_PEND: rd_data = {{CNT_W{1'b0}}, hv_pend};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
    parameter int CNT_W = 63
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W:0]   sv_cmp,
    input logic             soft_tick_set,
    input logic             hv_hit,
    input logic             hv_thread_live,
    input logic             hv_irq,
    input logic             wr_en,
    input logic [1:0]       wr_addr
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_en)) |-> (count_q == $past(count_q) + ONE)); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en)) |-> $stable(count_q)); // R2
    AST_SOFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_tick_set |=> !soft_tick_set); // R4
    AST_SOFT_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        soft_tick_set |-> (count_q == sv_cmp[CNT_W-1:0])); // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sv_cmp[CNT_W] |-> !soft_tick_set); // R5
    AST_HV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_thread_live |=> !hv_hit); // R8
    AST_HV_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hv_hit |=> hv_irq); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_irq && !(wr_en && wr_addr == 2'd3)) |=> hv_irq); // R7
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_en        (tick_en),
    .count_q        (count_q),
    .sv_cmp         (sv_cmp),
    .soft_tick_set  (soft_tick_set),
    .hv_hit         (hv_hit),
    .hv_thread_live (hv_thread_live),
    .hv_irq         (hv_irq),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr)
);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
    localparam int CNT_W = 4;
    localparam int MOD   = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             hv_thread_live = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W:0]   wr_data = '0;
    logic [1:0]       rd_addr = 2'd0;
    logic [CNT_W:0]   rd_data;
    logic             soft_tick_set;
    logic             hv_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_cmp_timer #(.CNT_W(CNT_W)) u_tick_cmp_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_en        (tick_en),
        .hv_thread_live (hv_thread_live),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .soft_tick_set  (soft_tick_set),
        .hv_irq         (hv_irq)
    );

    // read address walks all registers so every cycle samples one
    always @(posedge clk) rd_addr <= rd_addr + 2'd1;

    // requirement-level model
    logic [CNT_W-1:0] m_cnt;
    logic [CNT_W:0]   m_sv_cmp, m_hv_cmp;
    logic             m_sv_pulse, m_hv_pulse, m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt      <= '0;
            m_sv_cmp   <= {1'b1, {CNT_W{1'b0}}};
            m_hv_cmp   <= {1'b1, {CNT_W{1'b0}}};
            m_sv_pulse <= 1'b0;
            m_hv_pulse <= 1'b0;
            m_pend     <= 1'b0;
        end else begin
            m_cnt <= tick_en ? m_cnt + 1'b1 : m_cnt;
            m_sv_pulse <= !(wr_en && wr_addr == 2'd1) && !m_sv_cmp[CNT_W] && tick_en
                          && ((m_cnt + 1'b1) == m_sv_cmp[CNT_W-1:0]);
            m_hv_pulse <= !(wr_en && wr_addr == 2'd2) && !m_hv_cmp[CNT_W] && tick_en
                          && hv_thread_live && ((m_cnt + 1'b1) == m_hv_cmp[CNT_W-1:0]);
            if (wr_en && wr_addr == 2'd1) m_sv_cmp <= wr_data;
            if (wr_en && wr_addr == 2'd2) m_hv_cmp <= wr_data;
            if (m_hv_pulse)                    m_pend <= 1'b1;
            else if (wr_en && wr_addr == 2'd3) m_pend <= wr_data[0];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 soft_tick_set per cycle", 32'(soft_tick_set), 32'(m_sv_pulse));
            chk("R7 hv_irq per cycle", 32'(hv_irq), 32'(m_pend));
            case (rd_addr)
                2'd0: chk("R2 count readback", 32'(rd_data), 32'({1'b0, m_cnt}));
                2'd1: chk("R3 sv compare readback", 32'(rd_data), 32'(m_sv_cmp));
                2'd2: chk("R3 hv compare readback", 32'(rd_data), 32'(m_hv_cmp));
                default: chk("R11 pending readback", 32'(rd_data), 32'({{CNT_W{1'b0}}, m_pend}));
            endcase
        end
    end

    task automatic cyc(input logic te);
        tick_en = te;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        cyc(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at every address
        for (int i = 0; i < 4; i++) begin
            chk("R1 soft low", 32'(soft_tick_set), 32'd0);
            chk("R1 irq low", 32'(hv_irq), 32'd0);
            case (rd_addr)
                2'd0:    chk("R1 count zero", 32'(rd_data), 32'd0);
                2'd3:    chk("R1 pending zero", 32'(rd_data), 32'd0);
                default: chk("R1 compare disabled", 32'(rd_data), 32'(1 << CNT_W));
            endcase
            cyc(1'b0);
        end

        // R3: full-width readback, both disable-bit values
        wr(2'd1, 5'h1A);
        wr(2'd2, 5'h07);
        repeat (4) cyc(1'b0);
        wr(2'd1, 5'h10);
        wr(2'd2, 5'h10);
        repeat (4) cyc(1'b0);

        // R4/R6/R7: sweep every compare value on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int v = 0; v < MOD; v++) begin
                int c, d, first;
                c = int'(m_cnt);
                d = (v - c + MOD) % MOD;
                if (d == 0) d = MOD;
                wr(ch == 0 ? 2'd1 : 2'd2, {1'b0, 4'(v)});
                first = 0;
                for (int k = 1; k <= MOD + 2; k++) begin
                    cyc(1'b1);
                    if (first == 0 && (ch == 0 ? soft_tick_set : hv_irq)) first = k;
                end
                if (ch == 0)
                    chk(d == MOD ? "R6 sv fires after full wrap" : "R4 sv fire delay",
                        32'(first), 32'(d));
                else
                    chk(d == MOD ? "R6 hv fires after full wrap" : "R7 hv irq delay",
                        32'(first), 32'(d + 1));
                wr(ch == 0 ? 2'd1 : 2'd2, {1'b1, 4'(v)});
                wr(2'd3, 5'h00);
                if (ch == 1) chk("R7 irq cleared by write", 32'(hv_irq), 32'd0);
            end
        end

        // R5: disabled compare stays silent
        begin
            int n;
            n = 0;
            wr(2'd1, {1'b1, 4'd5});
            for (int k = 0; k < 2 * MOD; k++) begin
                cyc(1'b1);
                if (soft_tick_set) n++;
            end
            chk("R5 disabled compare pulses", 32'(n), 32'd0);
        end

        // R9: arm then cancel
        begin
            int n;
            logic [CNT_W-1:0] v;
            n = 0;
            v = m_cnt + 4'd3;
            wr(2'd1, {1'b0, v});
            wr(2'd1, {1'b1, v});
            for (int k = 0; k < 2 * MOD; k++) begin
                cyc(1'b1);
                if (soft_tick_set) n++;
            end
            chk("R9 cancelled match pulses", 32'(n), 32'd0);
        end

        // R8: thread down blocks hypervisor hits
        hv_thread_live = 1'b0;
        wr(2'd2, {1'b0, m_cnt + 4'd2});
        for (int k = 0; k < 2 * MOD; k++) cyc(1'b1);
        chk("R8 no irq while thread down", 32'(hv_irq), 32'd0);
        hv_thread_live = 1'b1;
        for (int k = 0; k < MOD + 1; k++) cyc(1'b1);
        chk("R8 irq once thread live", 32'(hv_irq), 32'd1);
        wr(2'd2, 5'h10);
        wr(2'd3, 5'h00);
        chk("R7 cleared", 32'(hv_irq), 32'd0);

        // R10: hit and clearing write in the same cycle
        wr(2'd2, {1'b0, m_cnt + 4'd2});
        cyc(1'b1);
        cyc(1'b1);
        wr(2'd3, 5'h00);
        chk("R10 set wins over clear", 32'(hv_irq), 32'd1);
        wr(2'd2, 5'h10);
        wr(2'd3, 5'h00);
        chk("R10 later clear", 32'(hv_irq), 32'd0);

        // R11: software may also raise the flag
        wr(2'd3, 5'h01);
        chk("R11 software raise", 32'(hv_irq), 32'd1);
        repeat (4) cyc(1'b0);
        wr(2'd3, 5'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule